// File: doc/BRIEF.md
# Chained Vector Element Sequencer

This block accepts one vector instruction at a time and feeds its elements, one per cycle, into a fixed-depth pipelined functional unit. Each instruction carries an element count, an operation code and a chain flag. For every element it issues, the sequencer raises a read strobe and an element index toward an external vector register file. The two operand values come back in the same cycle. After the pipeline depth, each result leaves on a write-back stream tagged with its element index, and a completion pulse marks the final element.

A chained instruction treats the instruction before it as its producer. It may read element i as soon as the producer's element i has been written back, so the two instructions overlap almost completely. An unchained instruction waits until every element of the previous instruction has been written. After the last element of any instruction enters the pipeline, a parameterised number of idle cycles must pass before the next instruction may enter.

Register storage, memory traffic and multiple lanes are handled outside the block.

Top module: `vchain_seq`

## Requirements
- R1: After reset, issueReady is 1 and srcRead, wbValid and vecDone are 0.
- R2: An instruction accepted in cycle c that is not held by a dependency reads elements 0, 1, 2 … in consecutive cycles from cycle c+1, with srcIdx equal to the element number. It reads no element beyond its length.
- R3: Each element read in cycle t appears with wbValid=1 and wbIdx equal to its index in cycle t+PIPE_DEPTH. Its data is the opA/opB value sampled in cycle t combined by issueOp, truncated to DATA_W bits: 0 gives a+b, 1 gives a−b, 2 gives the low half of a·b, and 3 gives a XOR b.
- R4: The element count is issueLen clamped to at most VLMAX. An issueLen of 0 is executed as one element.
- R5: After the last element read of an instruction in cycle t, no element is read in cycles t+1 … t+DEAD_CYC. An instruction already offered is accepted in cycle t+DEAD_CYC.
- R6: issueReady is 0 while an instruction still has more than one element to read. Otherwise a waiting instruction is accepted at the earliest cycle the other rules allow.
- R7: With issueChain=0, the first element is read no earlier than the cycle after the previous instruction's last write-back.
- R8: With issueChain=1, element i (below the producer's length) is read no earlier than the cycle after the producer's element i is written back.
- R9: With issueChain=1, elements at or beyond the producer's length are read no earlier than the cycle after the producer's last write-back.
- R10: A new instruction is not accepted before the instruction two places ahead of it has been fully written back (the cycle after its last write-back at the earliest).
- R11: vecDone is 1 exactly in the write-back cycle of each instruction's last element, and never without wbValid.
- R12: The write-back indices of each instruction run 0 … length−1 in order, each exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction offered |
| issueReady | output | 1 | Instruction taken this cycle when issueValid is 1 |
| issueLen | input | $clog2(VLMAX+1) | Requested element count |
| issueOp | input | 2 | Operation code (0 add, 1 subtract, 2 multiply, 3 xor) |
| issueChain | input | 1 | 1 = chain on the previous instruction's results |
| srcRead | output | 1 | Element read strobe toward the register file |
| srcIdx | output | $clog2(VLMAX) | Index of the element being read |
| opA | input | DATA_W | First operand of the element being read |
| opB | input | DATA_W | Second operand of the element being read |
| wbValid | output | 1 | Result element valid |
| wbIdx | output | $clog2(VLMAX) | Index of the result element |
| wbData | output | DATA_W | Result element value |
| vecDone | output | 1 | Last element of an instruction written back |

## Verification
The tightest overlap happens when a chained consumer reads an element in the cycle right after the producer writes it back, while the producer is still writing later elements. That same cycle can also be the one where the dead-time window expires and the following instruction is accepted. A sweep over every pairing of short, medium and full-length producers and consumers, with and without chaining and with a chained trailer, forces both coincidences. Each read, write-back and acceptance is judged against its cycle stamp, computed arithmetically from the length, depth and dead-time rules, and result data is judged against a shadow register file.

// File: rtl/vchain_pkg.sv
package vchain_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_XOR = 2'd3
  } vopE;

  // strobes handed from the sequencing control to the element datapath
  typedef struct packed {
    logic fire;   // an element enters the pipe this cycle
    logic last;   // it is the final element of its instruction
    logic tag;    // instruction parity, used to attribute write-backs
    vopE  op;     // operation applied to this element
  } ctrlStrobeT;

endpackage

// File: rtl/vchain_ctrl.sv
module vchain_ctrl
  import vchain_pkg::*;
#(
  parameter int VLMAX    = 64,
  parameter int DEAD_CYC = 4,
  parameter int LEN_W    = $clog2(VLMAX + 1),
  parameter int IDX_W    = $clog2(VLMAX)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  output logic             issueReady,
  input  logic [LEN_W-1:0] issueLen,
  input  logic [1:0]       issueOp,
  input  logic             issueChain,
  input  logic             wbValid,
  input  logic             wbTag,
  output ctrlStrobeT       strobe,
  output logic [IDX_W-1:0] elemIdx
);

  localparam int DEAD_W = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(VLMAX);

  logic             active;
  logic             curChain;
  logic             curTag;
  vopE              curOp;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] prodLen;
  logic [IDX_W-1:0] curIdx;
  logic [LEN_W-1:0] cntEven;
  logic [LEN_W-1:0] cntOdd;
  logic [DEAD_W-1:0] deadCnt;

  logic [LEN_W-1:0] effLen;
  logic [LEN_W-1:0] prodCnt;
  logic [LEN_W-1:0] idxExt;
  logic             prodDone;
  logic             chainOk;
  logic             elemOk;
  logic             fire;
  logic             lastFire;
  logic             slotFree;
  logic             accept;

  // clamp the requested length into 1 .. VLMAX
  always_comb begin
    if (issueLen == '0)          effLen = LEN_W'(1);
    else if (issueLen > MAX_LEN) effLen = MAX_LEN;
    else                         effLen = issueLen;
  end

  // the producer is the instruction before the current one (opposite tag)
  assign prodCnt  = curTag ? cntEven : cntOdd;
  assign prodDone = (prodCnt == prodLen);
  assign idxExt   = LEN_W'(curIdx);

  assign chainOk  = (prodCnt > idxExt) || prodDone;
  assign elemOk   = curChain ? chainOk : prodDone;
  assign fire     = active && elemOk;
  assign lastFire = fire && (idxExt == curLen - LEN_W'(1));

  generate
    if (DEAD_CYC == 0) begin : g_noDead
      assign slotFree = !active || lastFire;
    end else begin : g_dead
      assign slotFree = !active && (deadCnt <= DEAD_W'(1));
    end
  endgenerate

  assign issueReady = slotFree && prodDone;
  assign accept     = issueValid && issueReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active   <= 1'b0;
      curChain <= 1'b0;
      curTag   <= 1'b0;
      curOp    <= OP_ADD;
      curLen   <= '0;
      prodLen  <= '0;
      curIdx   <= '0;
      cntEven  <= '0;
      cntOdd   <= '0;
      deadCnt  <= '0;
    end else begin
      if (wbValid) begin
        if (wbTag) cntOdd  <= cntOdd + LEN_W'(1);
        else       cntEven <= cntEven + LEN_W'(1);
      end

      if (fire) begin
        curIdx <= curIdx + IDX_W'(1);
        if (lastFire) active <= 1'b0;
      end

      if (lastFire)             deadCnt <= DEAD_W'(DEAD_CYC);
      else if (deadCnt != '0)   deadCnt <= deadCnt - DEAD_W'(1);

      if (accept) begin
        active   <= 1'b1;
        curTag   <= !curTag;
        prodLen  <= curLen;
        curLen   <= effLen;
        curIdx   <= '0;
        curOp    <= vopE'(issueOp);
        curChain <= issueChain;
        // the new tag last belonged to a fully drained instruction
        if (curTag) cntEven <= '0;
        else        cntOdd  <= '0;
      end
    end
  end

  assign strobe.fire = fire;
  assign strobe.last = lastFire;
  assign strobe.tag  = curTag;
  assign strobe.op   = curOp;
  assign elemIdx     = curIdx;

endmodule

// File: rtl/vchain_dpath.sv
module vchain_dpath
  import vchain_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int IDX_W      = 6,
  parameter int PIPE_DEPTH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic [IDX_W-1:0]  elemIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbIdx,
  output logic              wbTag,
  output logic              wbLast,
  output logic [DATA_W-1:0] wbData
);

  localparam int TOP = PIPE_DEPTH - 1;

  logic [DATA_W-1:0] result;

  logic              vldQ  [PIPE_DEPTH];
  logic              lastQ [PIPE_DEPTH];
  logic              tagQ  [PIPE_DEPTH];
  logic [IDX_W-1:0]  idxQ  [PIPE_DEPTH];
  logic [DATA_W-1:0] datQ  [PIPE_DEPTH];

  always_comb begin
    unique case (strobe.op)
      OP_ADD:  result = opA + opB;
      OP_SUB:  result = opA - opB;
      OP_MUL:  result = opA * opB;
      default: result = opA ^ opB;
    endcase
  end

  generate
    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) vldQ[0] <= 1'b0;
          else       vldQ[0] <= strobe.fire;
        end
        always_ff @(posedge clk) begin
          lastQ[0] <= strobe.last;
          tagQ[0]  <= strobe.tag;
          idxQ[0]  <= elemIdx;
          datQ[0]  <= result;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) vldQ[s] <= 1'b0;
          else       vldQ[s] <= vldQ[s-1];
        end
        always_ff @(posedge clk) begin
          lastQ[s] <= lastQ[s-1];
          tagQ[s]  <= tagQ[s-1];
          idxQ[s]  <= idxQ[s-1];
          datQ[s]  <= datQ[s-1];
        end
      end
    end
  endgenerate

  assign wbValid = vldQ[TOP];
  assign wbLast  = lastQ[TOP];
  assign wbTag   = tagQ[TOP];
  assign wbIdx   = idxQ[TOP];
  assign wbData  = datQ[TOP];

endmodule

// File: rtl/vchain_seq.sv
module vchain_seq
  import vchain_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int VLMAX      = 64,
  parameter int PIPE_DEPTH = 6,
  parameter int DEAD_CYC   = 4,
  localparam int LEN_W     = $clog2(VLMAX + 1),
  localparam int IDX_W     = $clog2(VLMAX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  output logic              issueReady,
  input  logic [LEN_W-1:0]  issueLen,
  input  logic [1:0]        issueOp,
  input  logic              issueChain,
  output logic              srcRead,
  output logic [IDX_W-1:0]  srcIdx,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              wbValid,
  output logic [IDX_W-1:0]  wbIdx,
  output logic [DATA_W-1:0] wbData,
  output logic              vecDone
);

  ctrlStrobeT strobe;
  logic       wbTag;
  logic       wbLast;

  vchain_ctrl #(
    .VLMAX   (VLMAX),
    .DEAD_CYC(DEAD_CYC),
    .LEN_W   (LEN_W),
    .IDX_W   (IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueReady(issueReady),
    .issueLen  (issueLen),
    .issueOp   (issueOp),
    .issueChain(issueChain),
    .wbValid   (wbValid),
    .wbTag     (wbTag),
    .strobe    (strobe),
    .elemIdx   (srcIdx)
  );

  vchain_dpath #(
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .PIPE_DEPTH(PIPE_DEPTH)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .elemIdx(srcIdx),
    .opA    (opA),
    .opB    (opB),
    .wbValid(wbValid),
    .wbIdx  (wbIdx),
    .wbTag  (wbTag),
    .wbLast (wbLast),
    .wbData (wbData)
  );

  assign srcRead = strobe.fire;
  assign vecDone = wbValid && wbLast;

endmodule

// File: rtl/vchain_seq_chk.sv
module vchain_seq_chk #(
  parameter int VLMAX      = 64,
  parameter int PIPE_DEPTH = 6,
  parameter int DEAD_CYC   = 4,
  localparam int LEN_W     = $clog2(VLMAX + 1),
  localparam int IDX_W     = $clog2(VLMAX)
) (
  input logic             clk,
  input logic             rstN,
  input logic             issueValid,
  input logic             issueReady,
  input logic [LEN_W-1:0] issueLen,
  input logic             srcRead,
  input logic [IDX_W-1:0] srcIdx,
  input logic             wbValid,
  input logic [IDX_W-1:0] wbIdx,
  input logic             vecDone
);

  localparam int GAP_W = $clog2(DEAD_CYC + 2);

  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] wantLen;
  logic [GAP_W-1:0] gapLeft;
  logic [IDX_W-1:0] nextWb;
  logic             rdDly  [PIPE_DEPTH];
  logic [IDX_W-1:0] idxDly [PIPE_DEPTH];

  always_comb begin
    if (issueLen == '0)                  wantLen = LEN_W'(1);
    else if (issueLen > LEN_W'(VLMAX))   wantLen = LEN_W'(VLMAX);
    else                                 wantLen = issueLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      gapLeft   <= '0;
      nextWb    <= '0;
    end else begin
      if (issueValid && issueReady)        remaining <= wantLen;
      else if (srcRead && remaining != '0) remaining <= remaining - LEN_W'(1);

      if (srcRead && remaining == LEN_W'(1)) gapLeft <= GAP_W'(DEAD_CYC);
      else if (gapLeft != '0)                gapLeft <= gapLeft - GAP_W'(1);

      if (wbValid) nextWb <= vecDone ? '0 : wbIdx + IDX_W'(1);
    end
  end

  generate
    for (genvar s = 0; s < PIPE_DEPTH; s++) begin : g_dly
      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdDly[s]  <= 1'b0;
          idxDly[s] <= '0;
        end else if (s == 0) begin
          rdDly[s]  <= srcRead;
          idxDly[s] <= srcIdx;
        end else begin
          rdDly[s]  <= rdDly[s-1];
          idxDly[s] <= idxDly[s-1];
        end
      end
    end
  endgenerate

  // R2
  read_within_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    srcRead |-> remaining != '0);

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    gapLeft != '0 |-> !srcRead);

  // R6
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    remaining > LEN_W'(1) |-> !issueReady);

  // R3
  wb_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid == rdDly[PIPE_DEPTH-1]);

  // R3
  wb_index_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbIdx == idxDly[PIPE_DEPTH-1]);

  // R12
  wb_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> wbIdx == nextWb);

  // R11
  done_with_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecDone |-> wbValid);

endmodule

bind vchain_seq vchain_seq_chk #(
  .VLMAX     (VLMAX),
  .PIPE_DEPTH(PIPE_DEPTH),
  .DEAD_CYC  (DEAD_CYC)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .issueValid(issueValid),
  .issueReady(issueReady),
  .issueLen  (issueLen),
  .srcRead   (srcRead),
  .srcIdx    (srcIdx),
  .wbValid   (wbValid),
  .wbIdx     (wbIdx),
  .vecDone   (vecDone)
);

// File: tb/vchain_seq_bench.sv
module vchain_seq_bench;

  localparam int DW = 16;
  localparam int VM = 16;
  localparam int PD = 6;
  localparam int DC = 2;
  localparam int LW = $clog2(VM + 1);
  localparam int IW = $clog2(VM);
  localparam int LOGN = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic          issueReady;
  logic [LW-1:0] issueLen = '0;
  logic [1:0]    issueOp = '0;
  logic          issueChain = 1'b0;
  logic          srcRead;
  logic [IW-1:0] srcIdx;
  logic [DW-1:0] opA;
  logic [DW-1:0] opB;
  logic          wbValid;
  logic [IW-1:0] wbIdx;
  logic [DW-1:0] wbData;
  logic          vecDone;

  vchain_seq #(.DATA_W(DW), .VLMAX(VM), .PIPE_DEPTH(PD), .DEAD_CYC(DC)) u_vchain_seq (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueReady(issueReady),
    .issueLen(issueLen), .issueOp(issueOp), .issueChain(issueChain),
    .srcRead(srcRead), .srcIdx(srcIdx), .opA(opA), .opB(opB),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData), .vecDone(vecDone)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] initVal(int i);
    return DW'(i * 7 + 1);
  endfunction
  function automatic logic [DW-1:0] bVal(int i);
    return DW'(i * 3 + 5);
  endfunction
  function automatic logic [DW-1:0] applyOp(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      default: return a ^ b;
    endcase
  endfunction
  function automatic int effOf(int len);
    if (len == 0) return 1;
    if (len > VM) return VM;
    return len;
  endfunction
  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // register file model around the block
  logic [DW-1:0] rf [VM];
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < VM; i++) rf[i] <= initVal(i);
    end else if (wbValid) begin
      rf[wbIdx] <= wbData;
    end
  end
  always_comb opA = rf[srcIdx];
  always_comb opB = bVal(int'(srcIdx));

  // port log
  int rdCycL [LOGN];
  int rdIdxL [LOGN];
  int wbCycL [LOGN];
  int wbIdxL [LOGN];
  int wbDatL [LOGN];
  int wbDonL [LOGN];
  int nRd = 0;
  int nWb = 0;
  int strayDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (srcRead && nRd < LOGN) begin
        rdCycL[nRd] = cyc; rdIdxL[nRd] = int'(srcIdx); nRd++;
      end
      if (wbValid && nWb < LOGN) begin
        wbCycL[nWb] = cyc; wbIdxL[nWb] = int'(wbIdx);
        wbDatL[nWb] = int'(wbData); wbDonL[nWb] = int'(vecDone); nWb++;
      end else if (!wbValid && vecDone) begin
        strayDone++;
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // scenario description
  int sN;
  int sLen [8];
  int sOp [8];
  int sChain [8];
  int aE [8];
  int accObs [8];
  int effE [8];
  int rE [8][VM];
  logic [DW-1:0] rfExp [VM];

  task automatic runScenario();
    int rd0, wb0, start, g, tot, boundOffer, boundDead, boundProd, lp, dep, t;
    logic [DW-1:0] res;
    string tag;
    rd0 = nRd;
    wb0 = nWb;
    @(negedge clk);
    start = cyc;
    for (int k = 0; k < sN; k++) begin
      issueValid = 1'b1;
      issueLen   = LW'(sLen[k]);
      issueOp    = 2'(sOp[k]);
      issueChain = sChain[k][0];
      while (!issueReady) @(negedge clk);
      accObs[k] = cyc;
      @(negedge clk);
    end
    issueValid = 1'b0;
    repeat (sN * (VM + PD + DC + 3) + PD + 10) @(negedge clk);

    // expected schedule from the length, depth and dead-time rules
    tot = 0;
    for (int k = 0; k < sN; k++) begin
      effE[k] = effOf(sLen[k]);
      tot += effE[k];
      if (k == 0) begin
        aE[k] = start;
        tag = "R1";
      end else begin
        boundOffer = aE[k-1] + 1;
        boundDead  = rE[k-1][effE[k-1]-1] + DC;
        boundProd  = (k >= 2) ? rE[k-2][effE[k-2]-1] + PD + 1 : -1;
        aE[k] = imax(boundOffer, imax(boundDead, boundProd));
        if (boundProd > imax(boundOffer, boundDead)) tag = "R10";
        else if (boundDead > boundOffer)             tag = "R5";
        else                                         tag = "R6";
      end
      chk(accObs[k] == aE[k], tag, accObs[k], aE[k]);
      for (int i = 0; i < effE[k]; i++) begin
        t = (i == 0) ? aE[k] + 1 : rE[k][i-1] + 1;
        if (k > 0) begin
          lp = effE[k-1];
          if (sChain[k] != 0)
            dep = (i < lp) ? rE[k-1][i] + PD + 1 : rE[k-1][lp-1] + PD + 1;
          else
            dep = rE[k-1][lp-1] + PD + 1;
          t = imax(t, dep);
        end
        rE[k][i] = t;
      end
    end

    chk(nRd - rd0 == tot, "R4", nRd - rd0, tot);
    chk(nWb - wb0 == tot, "R12", nWb - wb0, tot);

    g = 0;
    for (int k = 0; k < sN; k++) begin
      for (int i = 0; i < effE[k]; i++) begin
        if (k == 0)                          tag = (sLen[k] != effE[k]) ? "R4" : "R2";
        else if (sChain[k] != 0)             tag = (i < effE[k-1]) ? "R8" : "R9";
        else if (i == 0)                     tag = "R7";
        else                                 tag = "R2";
        res = applyOp(sOp[k], rfExp[i], bVal(i));
        rfExp[i] = res;
        if (rd0 + g < nRd) begin
          chk(rdCycL[rd0+g] == rE[k][i], tag, rdCycL[rd0+g], rE[k][i]);
          chk(rdIdxL[rd0+g] == i, "R2", rdIdxL[rd0+g], i);
        end else begin
          chk(1'b0, tag, -1, rE[k][i]);
        end
        if (wb0 + g < nWb) begin
          chk(wbCycL[wb0+g] == rE[k][i] + PD, "R3", wbCycL[wb0+g], rE[k][i] + PD);
          chk(wbIdxL[wb0+g] == i, "R12", wbIdxL[wb0+g], i);
          chk(wbDatL[wb0+g] == int'(res), "R3", wbDatL[wb0+g], int'(res));
          chk(wbDonL[wb0+g] == ((i == effE[k] - 1) ? 1 : 0), "R11",
              wbDonL[wb0+g], (i == effE[k] - 1) ? 1 : 0);
        end else begin
          chk(1'b0, "R3", -1, rE[k][i] + PD);
        end
        g++;
      end
    end
  endtask

  initial begin
    int lens [4];
    lens[0] = 1; lens[1] = 2; lens[2] = 5; lens[3] = 16;
    for (int i = 0; i < VM; i++) rfExp[i] = initVal(i);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(issueReady == 1'b1, "R1", int'(issueReady), 1);
    chk(srcRead == 1'b0, "R1", int'(srcRead), 0);
    chk(wbValid == 1'b0, "R1", int'(wbValid), 0);
    chk(vecDone == 1'b0, "R1", int'(vecDone), 0);

    // sweep producer and consumer lengths, chaining and operations
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        for (int c = 0; c < 2; c++) begin
          sN = 3;
          sLen[0] = lens[a]; sOp[0] = (a + b) % 4;         sChain[0] = 0;
          sLen[1] = lens[b]; sOp[1] = (a + 2 * b + c) % 4; sChain[1] = c;
          sLen[2] = 3;       sOp[2] = (a + c + 1) % 4;     sChain[2] = 1;
          runScenario();
        end
      end
    end

    // R4 length clamping: zero and above the maximum
    sN = 4;
    sLen[0] = 0;  sOp[0] = 2; sChain[0] = 1;
    sLen[1] = 20; sOp[1] = 0; sChain[1] = 1;
    sLen[2] = 0;  sOp[2] = 3; sChain[2] = 0;
    sLen[3] = 7;  sOp[3] = 1; sChain[3] = 1;
    runScenario();

    // R11 no completion pulse outside a write-back
    chk(strayDone == 0, "R11", strayDone, 0);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule